// File: doc/BRIEF.md
# Dual-Vocabulary Instruction Expander

This block turns a compressed code word into a full 32-bit instruction. The word sits left-aligned in an input window. Its first bits are a 4-bit class code, and one or two table pointers come straight after it. Sixteen per-class configuration entries give each class its decode mode, its two pointer lengths, one table base for each vocabulary RAM, and a swap bit. Two 16-bit-wide vocabulary RAMs are loaded through a plain write port. The upper half of every result comes from the first RAM and the lower half from the second.

In shared mode a single pointer indexes a table in both RAMs, so one lookup rebuilds the whole word. In split mode each half has its own pointer. The swap bit decides which pointer goes to which RAM, so software can move the vocabularies between the two RAMs without changing the code stream. For every word it is offered, the block reports at once how many window bits the word takes up, which lets an upstream shifter realign the stream.

Words enter through a valid/ready handshake, and results leave through another. A word is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only while a finished result waits at the output with `out_ready` low. The result and its error flag stay unchanged until that result is taken. The configuration port and the vocabulary write port are plain strobes with no handshake.

Top module: `instr_expander`

## Requirements
- R1: Following reset, `out_valid` is 0, `in_ready` is 1 and all sixteen classes are disabled.
- R2: The class code occupies window bits [31:28]. Pointer 1 begins at bit 27 with its MSB first, and pointer 2 begins in the bit right after pointer 1 ends. Window bits past the consumed count do not affect the result.
- R3: In shared mode (mode 1), RAM1 is read at base1+p1 and RAM2 at base2+p1, and the output is {RAM1 word, RAM2 word}. `in_consumed` equals 4 plus len1, and len2 has no effect.
- R4: In split mode (mode 2) with swap at 0, the upper half comes from RAM1 at base1+p1 and the lower half from RAM2 at base2+p2. `in_consumed` equals 4 plus len1 plus len2.
- R5: In split mode with swap at 1, the upper half comes from RAM1 at base1+p2 and the lower half from RAM2 at base2+p1. The consumed count is the same as in R4.
- R6: Every RAM address is base plus pointer modulo 512.
- R7: A class whose mode is 0 or 3 gives `out_err`=1 with `out_data`=0, and its `in_consumed` is 4.
- R8: A written pointer length is stored clamped to the range 2 to 9.
- R9: `out_valid` rises on the cycle after an accept. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and the output is held unchanged.
- R10: Configuration field codes are: 0 mode (data[1:0]), 1 len1, 2 len2, 3 base1, 4 base2, 5 swap (data[0]). Codes 6 and 7 change nothing.
- R11: A vocabulary write with `voc_bank`=0 goes to RAM1 and with `voc_bank`=1 goes to RAM2, at `voc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cls | input | 4 | Class entry being written |
| cfg_field | input | 3 | Field code (R10) |
| cfg_data | input | 9 | Field value |
| voc_we | input | 1 | Vocabulary write strobe |
| voc_bank | input | 1 | 0 = RAM1 (upper half), 1 = RAM2 (lower half) |
| voc_addr | input | 9 | Vocabulary write address |
| voc_data | input | 16 | Vocabulary write data |
| in_valid | input | 1 | Window holds a word to decode |
| in_ready | output | 1 | Block can accept a word |
| in_window | input | 32 | Left-aligned compressed bits |
| in_consumed | output | 6 | Bits used by the word now offered |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Rebuilt instruction |
| out_err | output | 1 | Class was disabled |

## Verification
A pointer cut at the wrong offset or length shows up in the same cycle as a wrong `in_consumed`. It also shows up one cycle later as a RAM word from an unexpected address, and every vocabulary entry is made unique to its address so that such a miss is visible. A swap bit that is stored or applied wrongly exchanges the two pointers, so both halves come back from the wrong entries. A pipeline valid or stall flag that goes wrong shows as a lost, duplicated or changed result in the first cycle with `out_ready` low.

// File: rtl/ie_pkg.sv
package ie_pkg;
  parameter int CLS_W   = 4;
  parameter int NUM_CLS = 1 << CLS_W;
  parameter int LEN_W   = 4;
  parameter int VADDR_W = 9;
  parameter int PTR_MAX = VADDR_W;
  parameter int PTR_MIN = 2;
  parameter int HALF_W  = 16;
  parameter int FIELD_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SHARED = 2'd1,
    MODE_SPLIT  = 2'd2,
    MODE_RSVD   = 2'd3
  } cls_mode_e;

  typedef enum logic [FIELD_W-1:0] {
    FLD_MODE  = 3'd0,
    FLD_LEN1  = 3'd1,
    FLD_LEN2  = 3'd2,
    FLD_BASE1 = 3'd3,
    FLD_BASE2 = 3'd4,
    FLD_SWAP  = 3'd5
  } cfg_field_e;

  typedef struct packed {
    cls_mode_e            mode;
    logic [LEN_W-1:0]     len1;
    logic [LEN_W-1:0]     len2;
    logic [VADDR_W-1:0]   base1;
    logic [VADDR_W-1:0]   base2;
    logic                 swap;
  } cls_cfg_t;
endpackage

// File: rtl/ie_class_cfg.sv
module ie_class_cfg
  import ie_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CLS_W-1:0]   wcls,
  input  logic [FIELD_W-1:0] wfield,
  input  logic [VADDR_W-1:0] wdata,
  input  logic [CLS_W-1:0]   rcls,
  output cls_cfg_t           rcfg
);
  cls_cfg_t entries [NUM_CLS];

  function automatic logic [LEN_W-1:0] clamp_len(input logic [VADDR_W-1:0] v);
    if (v < VADDR_W'(PTR_MIN))      clamp_len = LEN_W'(PTR_MIN);
    else if (v > VADDR_W'(PTR_MAX)) clamp_len = LEN_W'(PTR_MAX);
    else                            clamp_len = v[LEN_W-1:0];
  endfunction

  generate
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          entries[c] <= '{mode: MODE_OFF, len1: LEN_W'(PTR_MIN), len2: LEN_W'(PTR_MIN),
                          base1: '0, base2: '0, swap: 1'b0};
        end else if (we && wcls == CLS_W'(c)) begin
          case (wfield)
            FLD_MODE:  entries[c].mode  <= cls_mode_e'(wdata[1:0]);
            FLD_LEN1:  entries[c].len1  <= clamp_len(wdata);
            FLD_LEN2:  entries[c].len2  <= clamp_len(wdata);
            FLD_BASE1: entries[c].base1 <= wdata;
            FLD_BASE2: entries[c].base2 <= wdata;
            FLD_SWAP:  entries[c].swap  <= wdata[0];
            default: ;
          endcase
        end
      end
    end
  endgenerate

  assign rcfg = entries[rcls];
endmodule

// File: rtl/ie_field_decode.sv
module ie_field_decode
  import ie_pkg::*;
#(
  parameter int WIN_W = 32,
  localparam int CNT_W = $clog2(WIN_W + 1)
) (
  input  logic [WIN_W-1:0]   window,
  input  cls_cfg_t           cfg,
  output logic               err,
  output logic [VADDR_W-1:0] addr1,
  output logic [VADDR_W-1:0] addr2,
  output logic [CNT_W-1:0]   consumed
);
  logic [WIN_W-1:0]   sh1, sh2;
  logic [PTR_MAX-1:0] raw1, raw2, p1, p2;
  logic [VADDR_W-1:0] ptr_a, ptr_b;
  logic               split, swap_eff;

  always_comb begin
    sh1  = window << CLS_W;
    raw1 = sh1[WIN_W-1 -: PTR_MAX];
    p1   = raw1 >> (LEN_W'(PTR_MAX) - cfg.len1);
    sh2  = sh1 << cfg.len1;
    raw2 = sh2[WIN_W-1 -: PTR_MAX];
    p2   = raw2 >> (LEN_W'(PTR_MAX) - cfg.len2);

    err      = (cfg.mode == MODE_OFF) || (cfg.mode == MODE_RSVD);
    split    = (cfg.mode == MODE_SPLIT);
    swap_eff = split && cfg.swap;

    ptr_a = VADDR_W'(p1);
    ptr_b = VADDR_W'(p1);
    if (split) ptr_b = VADDR_W'(p2);
    if (swap_eff) begin
      ptr_a = VADDR_W'(p2);
      ptr_b = VADDR_W'(p1);
    end
    addr1 = cfg.base1 + ptr_a;
    addr2 = cfg.base2 + ptr_b;

    consumed = CNT_W'(CLS_W);
    if (!err)  consumed = consumed + CNT_W'(cfg.len1);
    if (split) consumed = consumed + CNT_W'(cfg.len2);
  end
endmodule

// File: rtl/ie_vocab_ram.sv
module ie_vocab_ram #(
  parameter int AW = 9,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/instr_expander.sv
module instr_expander
  import ie_pkg::*;
#(
  parameter int WIN_W = 32,
  localparam int CNT_W = $clog2(WIN_W + 1),
  localparam int OUT_W = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CLS_W-1:0]   cfg_cls,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic [VADDR_W-1:0] cfg_data,
  input  logic               voc_we,
  input  logic               voc_bank,
  input  logic [VADDR_W-1:0] voc_addr,
  input  logic [HALF_W-1:0]  voc_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIN_W-1:0]   in_window,
  output logic [CNT_W-1:0]   in_consumed,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_err
);
  cls_cfg_t           cur_cfg;
  logic               dec_err;
  logic [VADDR_W-1:0] rd_addr [2];
  logic [HALF_W-1:0]  rd_word [2];
  logic               accept;
  logic               valid_q, err_q;

  ie_class_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wcls(cfg_cls), .wfield(cfg_field),
    .wdata(cfg_data), .rcls(in_window[WIN_W-1 -: CLS_W]), .rcfg(cur_cfg)
  );

  ie_field_decode #(.WIN_W(WIN_W)) u_dec (
    .window(in_window), .cfg(cur_cfg), .err(dec_err),
    .addr1(rd_addr[0]), .addr2(rd_addr[1]), .consumed(in_consumed)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      ie_vocab_ram #(.AW(VADDR_W), .DW(HALF_W)) u_ram (
        .clk(clk), .we(voc_we && (voc_bank == 1'(b))), .waddr(voc_addr),
        .wdata(voc_data), .re(accept), .raddr(rd_addr[b]), .rdata(rd_word[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      valid_q <= 1'b1;
      err_q   <= dec_err;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_err   = valid_q && err_q;
  assign out_data  = (valid_q && !err_q) ? {rd_word[0], rd_word[1]} : '0;
endmodule

// File: rtl/ie_chk.sv
module ie_chk #(
  parameter int CNT_W = 6,
  parameter int OUT_W = 32,
  parameter int MAX_USE = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CNT_W-1:0] in_consumed,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_err
);
  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R9
  no_accept_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_data == '0));

  // R3
  consumed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_consumed >= CNT_W'(4) && in_consumed <= CNT_W'(MAX_USE)));
endmodule

bind instr_expander ie_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_consumed(in_consumed), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_err(out_err)
);

// File: tb/instr_expander_test.sv
module instr_expander_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_cls = 0;
  logic [2:0]  cfg_field = 0;
  logic [8:0]  cfg_data = 0;
  logic        voc_we = 0, voc_bank = 0;
  logic [8:0]  voc_addr = 0;
  logic [15:0] voc_data = 0;
  logic        in_valid = 0, out_ready = 1;
  logic        in_ready, out_valid, out_err;
  logic [31:0] in_window = 0, out_data;
  logic [5:0]  in_consumed;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_expander uut (.*);

  function automatic logic [15:0] m1(input int a); return {7'h5A, 9'(a)}; endfunction
  function automatic logic [15:0] m2(input int a); return {7'h33, 9'(a)}; endfunction

  function automatic logic [31:0] mkwin(input int cls, input int p1, input int l1,
                                        input int p2, input int l2);
    logic [31:0] w;
    w = 32'(cls) << 28;
    w |= 32'(p1) << (28 - l1);
    w |= 32'(p2) << (28 - l1 - l2);
    w |= 32'hFFFF_FFFF >> (4 + l1 + l2);
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input int cls, input int fld, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_cls = 4'(cls); cfg_field = 3'(fld); cfg_data = 9'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_class(input int cls, input int mode, input int l1, input int l2,
                           input int b1, input int b2, input int sw);
    cfg(cls, 1, l1); cfg(cls, 2, l2); cfg(cls, 3, b1); cfg(cls, 4, b2);
    cfg(cls, 5, sw); cfg(cls, 0, mode);
  endtask

  task automatic run_word(input string req, input logic [31:0] win,
                          input logic [31:0] exp_data, input logic exp_err, input int exp_cons);
    @(negedge clk);
    in_valid = 1; in_window = win;
    #1;
    check({req, " consumed"}, 32'(in_consumed), 32'(exp_cons));
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " data"}, out_data, exp_data);
    check({req, " err"}, 32'(out_err), 32'(exp_err));
  endtask

  task automatic load_vocab();
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      voc_we = 1; voc_bank = 0; voc_addr = 9'(a); voc_data = m1(a);
      @(negedge clk);
      voc_bank = 1; voc_data = m2(a);
    end
    @(negedge clk);
    voc_we = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    run_word("R1 class disabled", mkwin(2, 0, 0, 0, 0), 0, 1, 4);
  endtask

  task automatic t_shared();
    set_class(3, 1, 5, 7, 10, 300, 0);
    // R3 R11: p1=0x13 -> RAM1[29], RAM2[319], len2 ignored
    run_word("R3 R11 shared", mkwin(3, 5'h13, 5, 0, 0), {m1(29), m2(319)}, 0, 9);
    // R2: different trailing bits do not matter
    run_word("R2 tail", {4'd3, 5'h13, 23'h0}, {m1(29), m2(319)}, 0, 9);
    // R10: field code 7 changes nothing
    cfg(3, 7, 0);
    run_word("R10 bad field", mkwin(3, 5'h13, 5, 0, 0), {m1(29), m2(319)}, 0, 9);
  endtask

  task automatic t_split();
    set_class(5, 2, 3, 9, 100, 200, 0);
    // R4 R6: 200+0x1AB wraps to 115
    run_word("R4 R6 split", mkwin(5, 5, 3, 9'h1AB, 9), {m1(105), m2(115)}, 0, 16);
  endtask

  task automatic t_swap();
    set_class(6, 2, 9, 2, 0, 50, 1);
    // R5: p1=0x155 -> RAM2 at 391, p2=2 -> RAM1 at 2
    run_word("R5 swap", mkwin(6, 9'h155, 9, 2, 2), {m1(2), m2(391)}, 0, 15);
  endtask

  task automatic t_disabled();
    cfg(10, 0, 3);
    run_word("R7 mode3", mkwin(10, 0, 5, 0, 0), 0, 1, 4);
    run_word("R7 mode0", mkwin(9, 0, 3, 0, 0), 0, 1, 4);
  endtask

  task automatic t_clamp();
    set_class(7, 2, 0, 15, 0, 0, 0);
    run_word("R8 clamp", mkwin(7, 3, 2, 9'h1FF, 9), {m1(3), m2(511)}, 0, 15);
  endtask

  task automatic t_wrap();
    set_class(4, 1, 5, 2, 500, 511, 0);
    run_word("R6 wrap", mkwin(4, 20, 5, 0, 0), {m1(8), m2(19)}, 0, 9);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_window = mkwin(5, 1, 3, 4, 9);
    @(negedge clk);
    in_window = mkwin(6, 7, 9, 3, 2);
    check("R9 in_ready low", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R9 held valid", 32'(out_valid), 1);
    check("R9 held data", out_data, {m1(101), m2(204)});
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9 next data", out_data, {m1(3), m2(57)});
    @(negedge clk);
    check("R9 drained", 32'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    load_vocab();
    t_shared();
    t_split();
    t_swap();
    t_disabled();
    t_clamp();
    t_wrap();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule